// File: doc/BRIEF.md
# Prescaled Down-Counter Timer

This block is an 8-bit timer that counts down. A 6-bit programmable prescaler sits in front of the counter and divides the stream of count events by a value that software selects. The counter can run once and halt, or it can reload and keep running. Each time it expires it sends a one-cycle request to an interrupt controller. Count events come from the block clock by default. An external input can also act as the event source, either with each rising edge as one event or as a level gate that qualifies the clock.

Software works through a write strobe with a 2-bit register address:

- **Address 0** holds the count start value.
- **Address 1** holds the prescaler divisor.
- **Address 2** is the control register:
  - bit 0 enables the timer.
  - bit 1 is restart-from-initial.
  - bit 2 selects continuous mode.
  - bits 4:3 select the event source.

The start value and the divisor wait in holding registers. They reach the working counters only on a restart or an automatic reload. The current count appears on a read port at all times, and reading it has no side effects.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count output is 0 and irq_o is 0. The timer is stopped, so the count stays 0 until a control write enables it.
- R2: A divisor of n (1..63) makes the counter step down once every n count events. A divisor of 0 means one step every 64 events. With the internal source (bits 4:3 = 00), one event occurs on every clock while enabled.
- R3: A start value of 0 gives 256 steps to expiry. The count reads 0, then 255, and so on down to 1, and then expires.
- R4: A control write with bit 1 set copies both holding registers into the working counters. The count output equals the start value on the next cycle, even while the timer is running.
- R5: Writes to address 0 or 1 leave the running count and its pace unchanged until the next restart or reload.
- R6: A control write with bit 0 clear freezes the count. A later write with bit 0 set and bit 1 clear resumes from the frozen value and the partly elapsed prescaler phase.
- R7: In single-pass mode (bit 2 = 0), the step from 1 leaves the count at 0. The timer then stops, with no further steps until software writes the control register again.
- R8: In continuous mode (bit 2 = 1), the step from 1 reloads the holding values and counting goes on. The count output shows the start value on the following cycle.
- R9: irq_o is high for exactly the one cycle after the clock edge on which the count expires from 1.
- R10: With bits 4:3 = 01, each rising edge of ext_in is one count event, after a two-stage synchronizer. The block clock alone does not step the count.
- R11: With bits 4:3 = 10, each clock on which the synchronized ext_in is high is one count event. No events occur while it is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 start value, 1 divisor, 2 control |
| wr_data | input | 8 | Write data |
| ext_in | input | 1 | External timer input (event edge or gate level) |
| count_o | output | 8 | Current count value (read without side effects) |
| irq_o | output | 1 | One-cycle expiry request |

## Verification

The bench sweeps small start values and divisors cycle by cycle. It catches an off-by-one in the prescaler reload, for example one that steps every n+1 events, because the expected count would then drift within a few cycles. It also catches an interrupt that arrives a cycle early or late.

The "0 means full range" encodings for both registers are tested at their ends. A design that treated 0 literally would expire immediately or never step.

The bench also covers two collision cases:
- **Stop during a prescaler tick.** A design that let the stop write win would lose one step.
- **Holding-register write during an active count.** A design that loaded the working counter directly would show the new value early.

## Source modes

Ext-edge and gate modes are checked against the synchronizer latency. A design that sampled ext_in raw, or counted clocks in edge mode, ends on a different count.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

   typedef enum logic [1:0] {
      SRC_CLK  = 2'b00,
      SRC_EDGE = 2'b01,
      SRC_GATE = 2'b10,
      SRC_RSV  = 2'b11
   } src_e;

   localparam logic [1:0] A_START = 2'd0;
   localparam logic [1:0] A_DIV   = 2'd1;
   localparam logic [1:0] A_CTL   = 2'd2;

   localparam int CB_EN      = 0;
   localparam int CB_RESTART = 1;
   localparam int CB_CONT    = 2;
   localparam int CB_SRC     = 3;
   localparam int CTL_BITS   = 5;

   typedef struct packed {
      logic en;
      logic restart;
      logic cont;
      src_e src;
   } ctl_t;

endpackage

// File: rtl/ptmr_regs.sv
module ptmr_regs
   import ptmr_pkg::*;
#(
   parameter int CNT_W = 8,
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   output logic [CNT_W-1:0] start_hold,
   output logic [PRE_W-1:0] div_hold,
   output logic             ctl_we,
   output ctl_t             ctl_wr,
   output logic             cont_q,
   output src_e             src_q
);

   assign ctl_we          = wr_en && (wr_addr == A_CTL);
   assign ctl_wr.en       = wr_data[CB_EN];
   assign ctl_wr.restart  = wr_data[CB_RESTART];
   assign ctl_wr.cont     = wr_data[CB_CONT];
   assign ctl_wr.src      = src_e'(wr_data[CB_SRC+1:CB_SRC]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         start_hold <= '0;
         div_hold   <= '0;
         cont_q     <= 1'b0;
         src_q      <= SRC_CLK;
      end else if (wr_en) begin
         if (wr_addr == A_START) start_hold <= wr_data;
         if (wr_addr == A_DIV)   div_hold   <= wr_data[PRE_W-1:0];
         if (ctl_we) begin
            cont_q <= ctl_wr.cont;
            src_q  <= ctl_wr.src;
         end
      end
   end

endmodule

// File: rtl/ptmr_src.sv
module ptmr_src
   import ptmr_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  src_e src,
   input  logic ext_in,
   output logic event_o
);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_s;
   logic                   prev_q;
   logic                   rise;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= ext_in;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
         end
      end
   endgenerate

   assign ext_s = sync_q[SYNC_STAGES-1];

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= ext_s;
   end

   assign rise = ext_s && !prev_q;

   always_comb begin
      unique case (src)
         SRC_EDGE: event_o = run && rise;
         SRC_GATE: event_o = run && ext_s;
         default:  event_o = run;
      endcase
   end

   p_gate_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_GATE && !ext_s) |-> !event_o);

   p_edge_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (src == SRC_EDGE && event_o) |=> !(src == SRC_EDGE && event_o));

endmodule

// File: rtl/ptmr_prescale.sv
module ptmr_prescale #(
   parameter int PRE_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PRE_W-1:0] div_i,
   input  logic             event_i,
   output logic             tick_o
);

   localparam logic [PRE_W-1:0] ONE = PRE_W'(1);

   logic [PRE_W-1:0] div_w;
   logic [PRE_W-1:0] ph_q;

   assign tick_o = event_i && (ph_q == ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         div_w <= '0;
         ph_q  <= '0;
      end else if (load_i) begin
         div_w <= div_i;
         ph_q  <= div_i;
      end else if (event_i) begin
         if (ph_q == ONE) ph_q <= div_w;
         else             ph_q <= ph_q - ONE;
      end
   end

   p_phase_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!event_i && !load_i) |=> $stable(ph_q));

endmodule

// File: rtl/ptmr_count.sv
module ptmr_count #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_we,
   input  logic             ctl_en,
   input  logic             ctl_restart,
   input  logic             cont,
   input  logic [CNT_W-1:0] start_hold,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_q,
   output logic             run_q,
   output logic             irq_q,
   output logic             restart_o,
   output logic             reload_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic expire;

   assign restart_o = ctl_we && ctl_restart;
   assign expire    = tick_i && !restart_o && (cnt_q == ONE);
   assign reload_o  = expire && cont;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         irq_q <= expire;
         if (restart_o)
            cnt_q <= start_hold;
         else if (tick_i) begin
            if (cnt_q == ONE) cnt_q <= cont ? start_hold : '0;
            else              cnt_q <= cnt_q - ONE;
         end
         if (ctl_we)
            run_q <= ctl_en;
         else if (expire && !cont)
            run_q <= 1'b0;
      end
   end

   p_irq_from_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq_q |-> ($past(cnt_q) == ONE));

   p_single_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q == ONE && !cont && !ctl_we) |=> (!run_q && cnt_q == '0 && irq_q));

   p_cont_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && cnt_q == ONE && cont && !ctl_we) |=> (run_q && irq_q && cnt_q == $past(start_hold)));

   p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !ctl_we) |=> $stable(cnt_q));

   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_we && ctl_restart) |=> (cnt_q == $past(start_hold)));

   p_run_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> $past(ctl_we || (tick_i && !cont)));

endmodule

// File: rtl/ptmr_top.sv
module ptmr_top
   import ptmr_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int PRE_W       = 6,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             ext_in,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_o
);

   generate
      if (CNT_W < CTL_BITS) begin : g_bad_cnt
         $error("ptmr_top: CNT_W must hold the control field");
      end
      if (PRE_W < 1 || PRE_W > CNT_W) begin : g_bad_pre
         $error("ptmr_top: PRE_W must be 1..CNT_W");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("ptmr_top: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] start_hold;
   logic [PRE_W-1:0] div_hold;
   logic             ctl_we;
   ctl_t             ctl_wr;
   logic             cont_q;
   src_e             src_q;
   logic             run_q;
   logic             ev;
   logic             tick;
   logic             restart;
   logic             reload;

   ptmr_regs #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_addr    (wr_addr),
      .wr_data    (wr_data),
      .start_hold (start_hold),
      .div_hold   (div_hold),
      .ctl_we     (ctl_we),
      .ctl_wr     (ctl_wr),
      .cont_q     (cont_q),
      .src_q      (src_q)
   );

   ptmr_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run_q),
      .src     (src_q),
      .ext_in  (ext_in),
      .event_o (ev)
   );

   ptmr_prescale #(.PRE_W(PRE_W)) u_pre (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (restart || reload),
      .div_i   (div_hold),
      .event_i (ev),
      .tick_o  (tick)
   );

   ptmr_count #(.CNT_W(CNT_W)) u_cnt (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctl_we      (ctl_we),
      .ctl_en      (ctl_wr.en),
      .ctl_restart (ctl_wr.restart),
      .cont        (cont_q),
      .start_hold  (start_hold),
      .tick_i      (tick),
      .cnt_q       (count_o),
      .run_q       (run_q),
      .irq_q       (irq_o),
      .restart_o   (restart),
      .reload_o    (reload)
   );

   p_no_tick_stopped_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run_q |-> !tick);

endmodule

// File: tb/sim_ptmr_top.sv
module sim_ptmr_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = 2'd0;
   logic [7:0] wr_data = 8'd0;
   logic       ext_in = 1'b0;
   logic [7:0] count_o;
   logic       irq_o;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   ptmr_top u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .ext_in  (ext_in),
      .count_o (count_o),
      .irq_o   (irq_o)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   function automatic logic [7:0] ctl(input bit en, input bit rs, input bit cn, input bit [1:0] s);
      return {3'b000, s, cn, rs, en};
   endfunction

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_single(input int l, input int p, input int k);
      int dec; int lv; int pv;
      lv = (l == 0) ? 256 : l;
      pv = (p == 0) ? 64 : p;
      dec = k / pv;
      return (dec >= lv) ? 0 : ((lv - dec) % 256);
   endfunction

   function automatic int exp_cont(input int l, input int p, input int k);
      int dec; int lv; int pv;
      lv = (l == 0) ? 256 : l;
      pv = (p == 0) ? 64 : p;
      dec = k / pv;
      return (lv - (dec % lv)) % 256;
   endfunction

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin : main
      step(3);
      chk("R1 count after reset", count_o, 0);
      chk("R1 irq after reset", irq_o, 0);
      step(5);
      chk("R1 stays stopped", count_o, 0);
      rst_n = 1'b1;
      step(2);

      // R2 R7 R9: sweep of single-pass runs
      for (int p = 1; p <= 4; p++) begin
         for (int l = 1; l <= 4; l++) begin
            wr(2'd0, 8'(l));
            wr(2'd1, 8'(p));
            wr(2'd2, ctl(1, 1, 0, 2'b00));
            chk("R4 start value loaded", count_o, l);
            for (int k = 1; k <= l * p + 2; k++) begin
               step(1);
               chk("R2 R7 single sweep count", count_o, exp_single(l, p, k));
               chk("R9 single sweep irq", irq_o, (k == l * p) ? 1 : 0);
            end
         end
      end

      // R2: divisor 0 means 64
      wr(2'd0, 8'd2); wr(2'd1, 8'd0); wr(2'd2, ctl(1, 1, 0, 2'b00));
      step(63); chk("R2 div64 before first step", count_o, 2);
      step(1);  chk("R2 div64 first step", count_o, 1);
      step(63); chk("R2 div64 no early expiry", irq_o, 0);
      step(1);  chk("R2 div64 expiry count", count_o, 0);
      chk("R9 div64 irq", irq_o, 1);

      // R3: start value 0 means 256 steps
      wr(2'd0, 8'd0); wr(2'd1, 8'd1); wr(2'd2, ctl(1, 1, 0, 2'b00));
      chk("R3 reads zero at start", count_o, 0);
      step(1);   chk("R3 wraps to 255", count_o, 255);
      step(254); chk("R3 reaches 1", count_o, 1);
      chk("R3 no irq yet", irq_o, 0);
      step(1);   chk("R3 expires", count_o, 0);
      chk("R3 irq", irq_o, 1);

      // R8 R9: continuous mode
      wr(2'd0, 8'd3); wr(2'd1, 8'd2); wr(2'd2, ctl(1, 1, 1, 2'b00));
      for (int k = 1; k <= 20; k++) begin
         step(1);
         chk("R8 continuous count", count_o, exp_cont(3, 2, k));
         chk("R9 continuous irq", irq_o, (k % 6 == 0) ? 1 : 0);
      end
      wr(2'd2, ctl(0, 0, 0, 2'b00));

      // R5: holding write during run; R8 reload takes new value
      wr(2'd0, 8'd4); wr(2'd1, 8'd1); wr(2'd2, ctl(1, 1, 1, 2'b00));
      chk("R4 restart value", count_o, 4);
      wr(2'd0, 8'd9);
      chk("R5 running count unaffected", count_o, 3);
      step(2); chk("R5 still old sequence", count_o, 1);
      step(1); chk("R8 reload from holding", count_o, 9);
      chk("R9 reload irq", irq_o, 1);
      step(1); chk("R9 irq one cycle", irq_o, 0);
      chk("R8 keeps counting", count_o, 8);
      wr(2'd0, 8'd20);
      wr(2'd2, ctl(1, 1, 0, 2'b00));
      chk("R4 restart while running", count_o, 20);
      wr(2'd2, ctl(0, 0, 0, 2'b00));

      // R6: stop and resume
      wr(2'd0, 8'd10); wr(2'd1, 8'd2); wr(2'd2, ctl(1, 1, 0, 2'b00));
      step(5); chk("R6 before stop", count_o, 8);
      wr(2'd2, ctl(0, 0, 0, 2'b00));
      chk("R6 step on stop edge kept", count_o, 7);
      step(10); chk("R6 frozen", count_o, 7);
      wr(2'd2, ctl(1, 0, 0, 2'b00));
      chk("R6 resume keeps value", count_o, 7);
      step(1); chk("R6 prescaler phase", count_o, 7);
      step(1); chk("R6 resumed step", count_o, 6);
      wr(2'd2, ctl(0, 0, 0, 2'b00));

      // R10: external edge source
      wr(2'd0, 8'd5); wr(2'd1, 8'd2); wr(2'd2, ctl(1, 1, 0, 2'b01));
      step(10); chk("R10 clock alone does not count", count_o, 5);
      for (int e = 0; e < 4; e++) begin
         ext_in = 1'b1; step(3);
         ext_in = 1'b0; step(3);
      end
      step(5); chk("R10 four edges divided by two", count_o, 3);
      wr(2'd2, ctl(0, 0, 0, 2'b00));

      // R11: gate source
      wr(2'd0, 8'd5); wr(2'd1, 8'd3); wr(2'd2, ctl(1, 1, 0, 2'b10));
      step(10); chk("R11 gate low holds", count_o, 5);
      ext_in = 1'b1; step(9);
      ext_in = 1'b0; step(6);
      chk("R11 nine gated clocks divided by three", count_o, 2);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule